// File: doc/BRIEF.md
# Software Store/Recall Sequence Detector

This block watches the asynchronous access strobes of a byte-wide nonvolatile SRAM and looks for a fixed unlock pattern of six consecutive reads. Each read is registered when chip enable falls. If the six addresses match the store pattern, the block sends the nonvolatile controller a store request. If the last address carries the recall code instead, it sends a recall request. Each request lasts one system clock. The same event raises a hold output, which keeps the SRAM disabled until the controller reports that its nonvolatile cycle has ended.

The strobes are brought into the system clock domain through a synchronizer, and the falling edge of chip enable is detected there. A write anywhere in the pattern resets the match, and so does a read from an unexpected address. A controller busy indication or a low-supply write inhibit also resets it. A stray read of the first pattern address is taken as a fresh first step. Output enable plays no part in detection.

Top module: `nvs_swseq_detect`

## Requirements
- R1: After reset, sw_store, sw_recall and chip_hold are all low.
- R2: Six chip-enable-controlled reads (write enable high) at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F, in that order, produce exactly one sw_store pulse and no sw_recall pulse.
- R3: The same first five reads followed by 0x0F0E produce exactly one sw_recall pulse and no sw_store pulse.
- R4: Write enable seen low during any enabled access resets the match. The remaining reads of the pattern then produce no request.
- R5: A read at an address other than the expected next one resets the match. This includes a sixth read that is neither 0x0F0F nor 0x0F0E. No request follows.
- R6: A mismatching read at 0x0000 counts as step one of a new pattern, so five further correct reads complete it.
- R7: The level of oe_n has no effect on detection.
- R8: chip_hold goes high together with a request and stays high until nv_busy falls. Reads made while chip_hold is high are not counted toward a pattern.
- R9: While nv_busy or low_vdd is high, the match is reset. Reads from before that period do not count toward a pattern.
- R10: Each request is high for exactly one clock. With the default two synchronizer stages, it is visible after the third rising clock edge that follows the falling edge of ce_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 13 | Memory address bus, held stable while ce_n is low |
| ce_n | input | 1 | Active-low chip enable (asynchronous) |
| we_n | input | 1 | Active-low write enable (asynchronous) |
| oe_n | input | 1 | Active-low output enable, not used for detection |
| nv_busy | input | 1 | Controller reports a nonvolatile cycle in progress |
| low_vdd | input | 1 | Writes inhibited because the supply is low |
| sw_store | output | 1 | One-clock software store request |
| sw_recall | output | 1 | One-clock software recall request |
| chip_hold | output | 1 | SRAM disabled pending the nonvolatile cycle |

## Verification
The only internal state is the step count of the partial match, so a wrong count shows up at the ports as a request that is missing or that should not be there. This appears no later than the sixth read after the fault, three clocks past that read's enable edge. For this reason each abort case finishes the remaining pattern reads and checks that nothing fires. After each abort, a complete pattern is also run, which shows that the count returned to a state from which the block can still detect the pattern. An exact-cycle check on one request catches changes in latency or pulse width, and the hold checks catch a hold that releases too early or a block that goes on counting while it is held.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int ADDR_W  = 13;
  localparam int SEQ_LEN = 6;
  localparam int STEP_W  = $clog2(SEQ_LEN);

  localparam logic [ADDR_W-1:0] STORE_END  = 13'h0F0F;
  localparam logic [ADDR_W-1:0] RECALL_END = 13'h0F0E;
  localparam logic [ADDR_W-1:0] FIRST_ADDR = 13'h0000;

  // expected address for steps 0..4 of the unlock pattern
  function automatic logic [ADDR_W-1:0] seq_addr(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    seq_addr = FIRST_ADDR;
      3'd1:    seq_addr = 13'h1555;
      3'd2:    seq_addr = 13'h0AAA;
      3'd3:    seq_addr = 13'h1FFF;
      default: seq_addr = 13'h10F0;
    endcase
  endfunction
endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nvs_seq_fsm.sv
module nvs_seq_fsm
  import nvs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_evt,
  input  logic              abort,
  input  logic [ADDR_W-1:0] addr,
  output logic              req_store,
  output logic              req_recall
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_LEN - 1);

  logic [STEP_W-1:0] step;
  logic              is_first;

  assign is_first = (addr == FIRST_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= '0;
      req_store  <= 1'b0;
      req_recall <= 1'b0;
    end else begin
      req_store  <= 1'b0;
      req_recall <= 1'b0;
      if (abort) begin
        step <= '0;
      end else if (rd_evt) begin
        if (step == LAST) begin
          req_store  <= (addr == STORE_END);
          req_recall <= (addr == RECALL_END);
          step       <= is_first ? STEP_W'(1) : '0;
        end else if (addr == seq_addr(step)) begin
          step <= step + STEP_W'(1);
        end else begin
          step <= is_first ? STEP_W'(1) : '0;
        end
      end
    end
  end

  // R9 / R4: an abort leaves no partial match and no request behind
  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (rst)
    abort |=> (step == '0) && !req_store && !req_recall);

  // R5: a request only follows a read at the final step
  assert_req_needs_read_R5: assert property (@(posedge clk) disable iff (rst)
    (req_store || req_recall) |-> $past(rd_evt) && ($past(step) == LAST));
endmodule

// File: rtl/nvs_swseq_detect.sv
module nvs_swseq_detect
  import nvs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              nv_busy,
  input  logic              low_vdd,
  output logic              sw_store,
  output logic              sw_recall,
  output logic              chip_hold
);
  logic [1:0] strb_s;
  logic       ce_s, we_s, ce_q, busy_q;
  logic       ce_fall, wr_seen, rd_evt, abort;

  nvs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ce_n, we_n}),
    .q   (strb_s)
  );

  assign ce_s = strb_s[1];
  assign we_s = strb_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      ce_q   <= ce_s;
      busy_q <= nv_busy;
    end
  end

  assign ce_fall = ce_q & ~ce_s;
  assign wr_seen = ~ce_s & ~we_s;
  assign rd_evt  = ce_fall & we_s;
  assign abort   = wr_seen | nv_busy | low_vdd | chip_hold;

  nvs_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .rd_evt     (rd_evt),
    .abort      (abort),
    .addr       (addr),
    .req_store  (sw_store),
    .req_recall (sw_recall)
  );

  always_ff @(posedge clk) begin
    if (rst)                        chip_hold <= 1'b0;
    else if (sw_store || sw_recall) chip_hold <= 1'b1;
    else if (busy_q && !nv_busy)    chip_hold <= 1'b0;
  end

  assert_one_kind_R2: assert property (@(posedge clk) disable iff (rst)
    !(sw_store && sw_recall));

  assert_store_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    sw_store |=> !sw_store);

  assert_recall_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    sw_recall |=> !sw_recall);

  assert_req_after_fall_R10: assert property (@(posedge clk) disable iff (rst)
    (sw_store || sw_recall) |-> $past(ce_fall));

  assert_hold_with_req_R8: assert property (@(posedge clk) disable iff (rst)
    (sw_store || sw_recall) |=> chip_hold);

  assert_hold_stays_R8: assert property (@(posedge clk) disable iff (rst)
    (chip_hold && !(busy_q && !nv_busy)) |=> chip_hold);

  assert_oe_known_R7: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(oe_n));
endmodule

// File: tb/nvs_swseq_detect_tb.sv
module nvs_swseq_detect_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] addr = '0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic        nv_busy = 1'b0, low_vdd = 1'b0;
  logic        sw_store, sw_recall, chip_hold;

  int checks = 0, failures = 0;
  int st_cnt = 0, rc_cnt = 0;
  bit prev_st = 0, prev_rc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nvs_swseq_detect u_dut (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .nv_busy(nv_busy), .low_vdd(low_vdd),
    .sw_store(sw_store), .sw_recall(sw_recall), .chip_hold(chip_hold)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (sw_store)  st_cnt++;
      if (sw_recall) rc_cnt++;
      if (sw_store && prev_st) begin
        failures++; $display("FAIL R10: store pulse width actual=2+ expected=1");
      end
      if (sw_recall && prev_rc) begin
        failures++; $display("FAIL R10: recall pulse width actual=2+ expected=1");
      end
      prev_st = sw_store;
      prev_rc = sw_recall;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [12:0] a, input bit wr);
    @(negedge clk);
    addr = a; we_n = ~wr; ce_n = 1'b0;
    repeat (4) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic prefix();
    cyc(13'h0000, 0); cyc(13'h1555, 0); cyc(13'h0AAA, 0);
    cyc(13'h1FFF, 0); cyc(13'h10F0, 0);
  endtask

  task automatic release_hold();
    @(negedge clk); nv_busy = 1'b1;
    repeat (3) @(negedge clk); nv_busy = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 store", sw_store, 0);
    chk("R1 recall", sw_recall, 0);
    chk("R1 hold", chip_hold, 0);
  endtask

  task automatic t_store();
    int s0 = st_cnt, r0 = rc_cnt;
    prefix(); cyc(13'h0F0F, 0);
    chk("R2 store count", st_cnt - s0, 1);
    chk("R2 no recall", rc_cnt - r0, 0);
    chk("R8 hold set", chip_hold, 1);
    prefix(); cyc(13'h0F0F, 0);
    chk("R8 ignored while held", st_cnt - s0, 1);
    chk("R8 hold kept", chip_hold, 1);
    release_hold();
    chk("R8 hold released", chip_hold, 0);
  endtask

  task automatic t_recall();
    int s0 = st_cnt, r0 = rc_cnt;
    prefix(); cyc(13'h0F0E, 0);
    chk("R3 recall count", rc_cnt - r0, 1);
    chk("R3 no store", st_cnt - s0, 0);
    release_hold();
  endtask

  task automatic t_timing();
    prefix();
    @(negedge clk); addr = 13'h0F0F; ce_n = 1'b0;
    @(negedge clk); chk("R10 edge1", sw_store, 0);
    @(negedge clk); chk("R10 edge2", sw_store, 0);
    @(negedge clk); chk("R10 edge3", sw_store, 1);
    @(negedge clk); chk("R10 edge4", sw_store, 0);
    ce_n = 1'b1;
    repeat (4) @(negedge clk);
    release_hold();
  endtask

  task automatic t_write();
    int s0 = st_cnt;
    cyc(13'h0000, 0); cyc(13'h1555, 0); cyc(13'h0AAA, 0);
    cyc(13'h1FFF, 1);
    cyc(13'h1FFF, 0); cyc(13'h10F0, 0); cyc(13'h0F0F, 0);
    chk("R4 write aborts", st_cnt - s0, 0);
    prefix(); cyc(13'h0F0F, 0);
    chk("R4 recovers", st_cnt - s0, 1);
    release_hold();
  endtask

  task automatic t_wrong();
    int s0 = st_cnt, r0 = rc_cnt;
    cyc(13'h0000, 0); cyc(13'h1555, 0); cyc(13'h0ABA, 0);
    cyc(13'h1FFF, 0); cyc(13'h10F0, 0); cyc(13'h0F0F, 0);
    chk("R5 wrong mid addr", st_cnt - s0, 0);
    prefix(); cyc(13'h0F0D, 0);
    chk("R5 wrong last store", st_cnt - s0, 0);
    chk("R5 wrong last recall", rc_cnt - r0, 0);
    chk("R5 no hold", chip_hold, 0);
  endtask

  task automatic t_restart();
    int s0 = st_cnt;
    cyc(13'h0000, 0); cyc(13'h1555, 0); cyc(13'h0000, 0);
    cyc(13'h1555, 0); cyc(13'h0AAA, 0); cyc(13'h1FFF, 0);
    cyc(13'h10F0, 0); cyc(13'h0F0F, 0);
    chk("R6 restart at step two", st_cnt - s0, 1);
    release_hold();
  endtask

  task automatic t_oe();
    int s0 = st_cnt;
    oe_n = 1'b1;
    prefix(); cyc(13'h0F0F, 0);
    oe_n = 1'b0;
    chk("R7 oe high still stores", st_cnt - s0, 1);
    release_hold();
  endtask

  task automatic t_busy();
    int s0 = st_cnt;
    cyc(13'h0000, 0); cyc(13'h1555, 0); cyc(13'h0AAA, 0);
    @(negedge clk); nv_busy = 1'b1; repeat (2) @(negedge clk); nv_busy = 1'b0;
    cyc(13'h1FFF, 0); cyc(13'h10F0, 0); cyc(13'h0F0F, 0);
    chk("R9 busy resets", st_cnt - s0, 0);
    cyc(13'h0000, 0); cyc(13'h1555, 0); cyc(13'h0AAA, 0);
    @(negedge clk); low_vdd = 1'b1; repeat (2) @(negedge clk); low_vdd = 1'b0;
    cyc(13'h1FFF, 0); cyc(13'h10F0, 0); cyc(13'h0F0F, 0);
    chk("R9 low supply resets", st_cnt - s0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_store();
    t_recall();
    t_timing();
    t_write();
    t_wrong();
    t_restart();
    t_oe();
    t_busy();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule